// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is a synthesizable model of a synchronous, pipelined burst static memory. It has a parameterised number of word addresses and four byte lanes of eight bits each. Every control input is sampled on the rising clock edge. The exceptions are the output enable, the burst-order select and the sleep input, which act without the clock. A cycle starts from one of two address strobes. The processor strobe always starts a read. The controller strobe starts a read or a write, decided by the write controls. Each start loads the external address. The following edges walk a four-beat burst through the low two address bits, moving only on edges where the active-low advance input is low.

Read data passes two registers before it reaches the output, so a read returns its data two edges after its access. The block does not drive a three-state bus. It drives a data word together with a valid flag, and the word is forced to zero whenever the flag is low. A sleep input blanks the output and keeps the stored contents. After sleep is released, the block ignores strobes for a fixed wake interval.

The cycle control is a state machine with six states:
- ST_IDLE: no burst is open.
- ST_READ: a burst is open and its last access was a read.
- ST_WRITE: a burst is open and its last access was a write.
- ST_SLEEP: the block is powered down.
- ST_WAKE1 and ST_WAKE2: the two wake-up states.

The transitions are:
- Start: from IDLE, READ or WRITE to READ or WRITE, taken when a strobe is accepted with every select active.
- Deselect: from IDLE, READ or WRITE to IDLE, taken when a strobe is seen while any select is inactive.
- Continue: from READ or WRITE to READ or WRITE, taken when no strobe is accepted and a burst is open.
- Doze: from any state to SLEEP, taken whenever sleep is sampled high.
- Rouse: from SLEEP to WAKE1.
- Settle: from WAKE1 to WAKE2.
- Ready: from WAKE2 to IDLE.

Top module: `burst_sram_ctrl`

## Requirements
- R1: After reset, rdata_en is 0 and rdata is 0, and no burst is open.
- R2: When strb_proc_n is low, sel_pri_n is low and every select is active (sel_pri_n low, sel_hi high, sel_lo_n low), the edge loads addr and starts a read. The write controls are ignored on that edge. With oe_n low, the data appears on rdata with rdata_en high after the second following rising edge.
- R3: When strb_ctrl_n is low, strb_proc_n is high and every select is active, the edge loads addr and samples the write controls, so the access is a write if any lane is enabled and a read otherwise.
- R4: When sel_pri_n is high, the processor strobe has no effect. A strobe that is accepted while any select is inactive closes the burst and performs no access.
- R5: The lane enables are decoded as follows. With gwr_n low, all four lanes are written. With gwr_n high and bwe_n low, lane i (wdata bits 8i+7 down to 8i) is written when lane_we_n bit i is 0. With gwr_n and bwe_n both high, the access is a read.
- R6: On a burst edge with no strobe, adv_n low moves the access to the next burst address, and adv_n high repeats the current address. Each such edge reads or writes according to the write controls.
- R7: With ileave at 0, beat k of a burst uses low address bits (start + k) mod 4.
- R8: With ileave at 1, beat k of a burst uses low address bits start XOR k. The upper address bits hold their value for the whole burst.
- R9: rdata_en is high only while oe_n is low. It is held low during the cycle after any write edge. rdata is 0 whenever rdata_en is low.
- R10: While sleep is high, rdata_en is 0 and no access takes place, and the stored data is kept.
- R11: Strobes are ignored on the first edge that samples sleep low and on the two edges after it.
- R12: A read of an address issued on the edge after a write to that address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_pri_n | input | 1 | Primary chip select, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| gwr_n | input | 1 | Whole-word write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| ileave | input | 1 | Burst order select: 1 for interleaved, 0 for linear |
| sleep | input | 1 | Power-down request, active high |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data; zero when not valid |
| rdata_en | output | 1 | Read data valid (stands in for the output drivers) |

## Verification
The assertions rely on a few assumptions about the inputs. The sleep and output-enable inputs may only change away from the rising edge. No strobe is meant to be acted on within the wake window, so any access recorded there is an error. The stimulus applies every input on the falling edge and keeps sleep low throughout reset. It samples outputs on the falling edge, where two-edge pipeline timing can be counted exactly. It does issue strobes inside the wake window, on purpose. These probes check that the block drops them rather than asking the environment to hold strobes back.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_SLEEP,
        ST_WAKE1,
        ST_WAKE2
    } cyc_state_e;

    localparam int BEAT_W = 2;

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              load,
    input  logic              step,
    input  logic              ileave,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_eff;
    logic [BEAT_W-1:0] low_bits;

    // beat count used by this edge's access
    always_comb begin
        beat_eff = step ? beat_q + 1'b1 : beat_q;
    end

    generate
        if (BEAT_W == 2) begin : g_order
            // linear order wraps modulo four, interleaved order xors the beat
            always_comb begin
                if (ileave) begin
                    low_bits = base_q[BEAT_W-1:0] ^ beat_eff;
                end else begin
                    low_bits = base_q[BEAT_W-1:0] + beat_eff;
                end
            end
        end else begin : g_order_other
            always_comb begin
                low_bits = base_q[BEAT_W-1:0] + beat_eff;
            end
        end
    endgenerate

    always_comb begin
        if (load) begin
            acc_addr = ext_addr;
        end else begin
            acc_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (acc_en) begin
            if (load) begin
                base_q <= ext_addr;
                beat_q <= '0;
            end else begin
                beat_q <= beat_eff;
            end
        end
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = base_q[ADDR_W-1:BEAT_W];

endmodule

// File: rtl/burst_sram_fsm.sv
module burst_sram_fsm
    import burst_sram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strb_proc_n,
    input  logic             strb_ctrl_n,
    input  logic             adv_n,
    input  logic             sel_pri_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             gwr_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             sleep,
    output logic             acc_en,
    output logic             acc_wr,
    output logic             load,
    output logic             step,
    output logic [LANES-1:0] lane_mask
);

    cyc_state_e state_q;
    cyc_state_e state_d;

    logic [LANES-1:0] wr_mask;
    logic             wr_req;
    logic             all_sel;
    logic             start_p;
    logic             start_c;
    logic             start_any;
    logic             awake;
    logic             in_burst;

    always_comb begin
        if (!gwr_n) begin
            wr_mask = '1;
        end else if (!bwe_n) begin
            wr_mask = ~lane_we_n;
        end else begin
            wr_mask = '0;
        end
    end

    assign wr_req    = |wr_mask;
    assign all_sel   = !sel_pri_n && sel_hi && !sel_lo_n;
    assign start_p   = !strb_proc_n && !sel_pri_n;
    assign start_c   = !strb_ctrl_n && (strb_proc_n || sel_pri_n);
    assign start_any = start_p || start_c;
    assign in_burst  = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign awake     = !sleep && (in_burst || state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (sleep) begin
            state_d = ST_SLEEP;
        end else begin
            unique case (state_q)
                ST_SLEEP: state_d = ST_WAKE1;
                ST_WAKE1: state_d = ST_WAKE2;
                ST_WAKE2: state_d = ST_IDLE;
                ST_IDLE, ST_READ, ST_WRITE: begin
                    if (start_any) begin
                        if (!all_sel) begin
                            state_d = ST_IDLE;
                        end else if (start_p) begin
                            state_d = ST_READ;
                        end else begin
                            state_d = wr_req ? ST_WRITE : ST_READ;
                        end
                    end else if (in_burst) begin
                        state_d = wr_req ? ST_WRITE : ST_READ;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        acc_en    = 1'b0;
        acc_wr    = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        lane_mask = '0;
        if (awake) begin
            if (start_any) begin
                if (all_sel) begin
                    acc_en = 1'b1;
                    load   = 1'b1;
                    acc_wr = !start_p && wr_req;
                end
            end else if (in_burst) begin
                acc_en = 1'b1;
                acc_wr = wr_req;
                step   = !adv_n;
            end
        end
        if (acc_wr) begin
            lane_mask = wr_mask;
        end
    end

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_en,
    input  logic                    acc_wr,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_q,
    output logic                    rd_v
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];
            logic [LANE_W-1:0] lane_q;

            always_ff @(posedge clk) begin
                if (acc_en && acc_wr && lane_mask[g]) begin
                    mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else if (acc_en && !acc_wr) begin
                    lane_q <= mem[acc_addr];
                end
            end

            assign rd_q[g*LANE_W +: LANE_W] = lane_q;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_v <= 1'b0;
        end else begin
            rd_v <= acc_en && !acc_wr;
        end
    end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import burst_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strb_proc_n,
    input  logic                    strb_ctrl_n,
    input  logic                    adv_n,
    input  logic                    sel_pri_n,
    input  logic                    sel_hi,
    input  logic                    sel_lo_n,
    input  logic                    gwr_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    oe_n,
    input  logic                    ileave,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_en
);

    localparam int DATA_W = LANES * LANE_W;

    logic              acc_en;
    logic              acc_wr;
    logic              load;
    logic              step;
    logic [LANES-1:0]  lane_mask;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] rd_q;
    logic              rd_v;
    logic [DATA_W-1:0] out_q;
    logic              out_v;
    logic              wr_seen;

    burst_sram_fsm #(
        .LANES (LANES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .adv_n       (adv_n),
        .sel_pri_n   (sel_pri_n),
        .sel_hi      (sel_hi),
        .sel_lo_n    (sel_lo_n),
        .gwr_n       (gwr_n),
        .bwe_n       (bwe_n),
        .lane_we_n   (lane_we_n),
        .sleep       (sleep),
        .acc_en      (acc_en),
        .acc_wr      (acc_wr),
        .load        (load),
        .step        (step),
        .lane_mask   (lane_mask)
    );

    burst_addr_gen #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (acc_en),
        .load     (load),
        .step     (step),
        .ileave   (ileave),
        .ext_addr (addr),
        .acc_addr (acc_addr)
    );

    burst_sram_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .lane_mask (lane_mask),
        .acc_addr  (acc_addr),
        .wdata     (wdata),
        .rd_q      (rd_q),
        .rd_v      (rd_v)
    );

    // second pipeline stage: output buffer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q   <= '0;
            out_v   <= 1'b0;
            wr_seen <= 1'b0;
        end else begin
            out_q   <= rd_q;
            out_v   <= rd_v;
            wr_seen <= acc_en && acc_wr;
        end
    end

    assign rdata_en = out_v && !wr_seen && !oe_n && !sleep;
    assign rdata    = rdata_en ? out_q : '0;

endmodule

// File: rtl/burst_sram_checker.sv
module burst_sram_checker (
    input logic clk,
    input logic rst_n,
    input logic sleep,
    input logic oe_n,
    input logic rdata_en,
    input logic acc_en,
    input logic acc_wr
);

    assert_sleep_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !rdata_en);

    assert_oe_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_en);

    assert_write_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_en && acc_wr) |-> !rdata_en);

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_en |-> $past(acc_en && !acc_wr, 2));

    assert_wake_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> (!sleep && !$past(sleep, 1) && !$past(sleep, 2) && !$past(sleep, 3)));

    assert_no_access_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !acc_en);

endmodule

bind burst_sram_ctrl burst_sram_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .oe_n     (oe_n),
    .rdata_en (rdata_en),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr)
);

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctrl_bench;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strb_proc_n = 1'b1;
    logic          strb_ctrl_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          sel_pri_n = 1'b0;
    logic          sel_hi = 1'b1;
    logic          sel_lo_n = 1'b0;
    logic          gwr_n = 1'b1;
    logic          bwe_n = 1'b1;
    logic [3:0]    lane_we_n = 4'hF;
    logic          oe_n = 1'b0;
    logic          ileave = 1'b0;
    logic          sleep = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rdata_en;

    int checks = 0;
    int fails = 0;
    logic [31:0] model [DEPTH];

    always #4 clk = ~clk;

    burst_sram_ctrl #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) u_burst_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(strb_proc_n),
        .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .sel_pri_n(sel_pri_n),
        .sel_hi(sel_hi), .sel_lo_n(sel_lo_n), .gwr_n(gwr_n), .bwe_n(bwe_n),
        .lane_we_n(lane_we_n), .oe_n(oe_n), .ileave(ileave), .sleep(sleep),
        .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    function automatic logic [31:0] pat(input int a, input int salt);
        return 32'((a + 1) * 32'h9E37_79B9) ^ 32'(salt);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_idle();
        strb_proc_n = 1'b1; strb_ctrl_n = 1'b1; adv_n = 1'b1;
        sel_pri_n = 1'b0; sel_hi = 1'b1; sel_lo_n = 1'b0;
        gwr_n = 1'b1; bwe_n = 1'b1; lane_we_n = 4'hF; oe_n = 1'b0;
    endtask

    task automatic chk(input string tag, input logic exp_en, input logic [31:0] exp_d);
        logic [31:0] want;
        want = exp_en ? exp_d : 32'h0;
        checks++;
        if (rdata_en !== exp_en || rdata !== want) begin
            fails++;
            $display("FAIL %s: rdata_en=%0b rdata=%h expected rdata_en=%0b rdata=%h",
                     tag, rdata_en, rdata, exp_en, want);
        end
    endtask

    function automatic int beat_addr(input int base, input int k, input logic mode);
        logic [1:0] lo;
        lo = mode ? (2'(base) ^ 2'(k)) : (2'(base) + 2'(k));
        return (base & ~3) | int'(lo);
    endfunction

    // controller-strobe burst write of four beats, whole word
    task automatic wr_burst(input int base, input logic mode);
        set_idle();
        ileave = mode;
        for (int k = 0; k < 4; k++) begin
            int a;
            a = beat_addr(base, k, mode);
            if (k == 0) begin
                strb_ctrl_n = 1'b0; addr = AW'(base);
            end else begin
                strb_ctrl_n = 1'b1; adv_n = 1'b0;
            end
            gwr_n = 1'b0;
            wdata = pat(a, 0);
            model[a] = wdata;
            tick();
            chk("R9 blank after write", 1'b0, 32'h0);
        end
        set_idle();
    endtask

    // processor-strobe burst read of four beats, pipelined check
    task automatic rd_burst(input int base, input logic mode, input string tag);
        set_idle();
        ileave = mode;
        strb_proc_n = 1'b0; addr = AW'(base);
        tick();
        for (int k = 1; k <= 4; k++) begin
            set_idle();
            adv_n = (k == 4);
            tick();
            chk(tag, 1'b1, model[beat_addr(base, k - 1, mode)]);
        end
    endtask

    task automatic rd_one(input int a, input string tag);
        set_idle();
        strb_proc_n = 1'b0; addr = AW'(a);
        tick();
        set_idle();
        tick();
        chk(tag, 1'b1, model[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        set_idle();
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 1'b0, 32'h0);
        rst_n = 1'b1;
        tick();
        tick();
        chk("R1 idle after reset", 1'b0, 32'h0);

        // R3 R7: fill every address with linear bursts from varied start beats
        for (int b = 0; b < DEPTH / 4; b++) begin
            wr_burst(b * 4 + (b % 4), 1'b0);
        end

        // R8: interleaved readback, R7: linear readback, R2 latency
        for (int b = 0; b < DEPTH / 4; b++) begin
            rd_burst(b * 4 + ((b + 1) % 4), 1'b1, "R8 interleaved read");
            if (b % 2 == 0) rd_burst(b * 4 + 3, 1'b0, "R7 linear read");
        end

        // R6: suspend holds address, advance moves it
        set_idle(); ileave = 1'b0;
        strb_proc_n = 1'b0; addr = AW'(17);
        tick();
        set_idle(); tick();
        chk("R6 start beat", 1'b1, model[17]);
        set_idle(); tick();
        chk("R6 suspended beat", 1'b1, model[17]);
        set_idle(); adv_n = 1'b0; tick();
        chk("R6 second suspend", 1'b1, model[17]);
        set_idle(); tick();
        chk("R6 advanced beat", 1'b1, model[18]);

        // R5: every per-lane enable pattern
        for (int m = 0; m < 16; m++) begin
            int a;
            a = 32 + m;
            set_idle();
            strb_ctrl_n = 1'b0; addr = AW'(a);
            bwe_n = 1'b0; lane_we_n = 4'(m);
            wdata = pat(a, 32'h5A5A_0000);
            for (int l = 0; l < 4; l++) begin
                if (!m[l]) model[a][l*8 +: 8] = wdata[l*8 +: 8];
            end
            tick();
        end
        // both qualifiers high: read, lanes low are ignored
        set_idle(); strb_ctrl_n = 1'b0; addr = AW'(48); lane_we_n = 4'h0;
        wdata = 32'hDEAD_BEEF; tick();
        // whole-word write overrides lane enables
        set_idle(); strb_ctrl_n = 1'b0; addr = AW'(49); gwr_n = 1'b0; bwe_n = 1'b1;
        lane_we_n = 4'hF; wdata = pat(49, 7); model[49] = wdata; tick();
        for (int a = 32; a < 50; a++) rd_one(a, "R5 lane write");

        // R2: write controls ignored on a processor start
        set_idle(); strb_proc_n = 1'b0; strb_ctrl_n = 1'b0; addr = AW'(5);
        gwr_n = 1'b0; wdata = 32'h1234_5678; tick();
        set_idle(); tick();
        chk("R2 processor start reads", 1'b1, model[5]);
        rd_one(5, "R2 no write on processor start");

        // R4: deselect with a write pending, then blocked processor strobe
        set_idle(); strb_ctrl_n = 1'b0; sel_hi = 1'b0; addr = AW'(7);
        gwr_n = 1'b0; wdata = 32'hCAFE_0007; tick();
        set_idle(); tick();
        chk("R4 deselect no access", 1'b0, 32'h0);
        set_idle(); sel_pri_n = 1'b1; strb_proc_n = 1'b0; addr = AW'(8); tick();
        set_idle(); tick();
        chk("R4 blocked strobe", 1'b0, 32'h0);
        set_idle(); tick();
        chk("R4 blocked strobe later", 1'b0, 32'h0);
        rd_one(7, "R4 deselected write dropped");

        // R9: output enable gates asynchronously
        set_idle(); strb_proc_n = 1'b0; addr = AW'(9); tick();
        set_idle(); oe_n = 1'b1; tick();
        chk("R9 oe high", 1'b0, 32'h0);
        oe_n = 1'b0; #1;
        chk("R9 oe low", 1'b1, model[9]);
        @(negedge clk);

        // R12: read right after write to same address
        set_idle(); strb_ctrl_n = 1'b0; addr = AW'(20); gwr_n = 1'b0;
        wdata = 32'h0BAD_F00D; model[20] = wdata; tick();
        set_idle(); strb_proc_n = 1'b0; addr = AW'(20); tick();
        set_idle(); tick();
        chk("R12 read after write", 1'b1, 32'h0BAD_F00D);

        // R10: sleep blanks output, keeps contents
        set_idle(); strb_ctrl_n = 1'b0; addr = AW'(21); gwr_n = 1'b0;
        wdata = 32'h7777_2121; model[21] = wdata; tick();
        set_idle(); strb_proc_n = 1'b0; addr = AW'(21); tick();
        set_idle(); sleep = 1'b1; tick();
        chk("R10 asleep blank", 1'b0, 32'h0);
        for (int i = 0; i < 3; i++) begin
            strb_proc_n = 1'b0; tick();
            chk("R10 asleep no read", 1'b0, 32'h0);
        end
        // R11: strobes on the release edge and the next two are dropped
        sleep = 1'b0;
        for (int i = 0; i < 3; i++) begin
            set_idle(); strb_proc_n = 1'b0; addr = AW'(22); tick();
            if (i > 0) chk("R11 wake strobe ignored", 1'b0, 32'h0);
        end
        set_idle(); tick();
        chk("R11 last wake strobe ignored", 1'b0, 32'h0);
        rd_one(21, "R10 contents kept");
        rd_one(22, "R11 operating after wake");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule